// File: doc/BRIEF.md
# Sectioned Register Window Controller

This block sits behind a serial-bus front end and serves byte reads and writes into a small clock and control register space. The space is split into five sections: two alarm banks, a control bank, a bank of running time bytes and a one-byte status register. The front end has already decoded the bus protocol. It hands over one-cycle strobes for transfer start, transfer stop, address load, write byte and read request.

An internal pointer walks through the current section with each access. When it passes the last byte of the section it wraps to the first byte of the same section. It never moves into a neighbouring section. The time bytes are frozen into a snapshot at every start, so a read is not affected by the counter moving underneath it.

Written bytes are held in a staging buffer. They reach the registers only when the stop arrives, and only if the write-enable bit in status is set. The status register itself is always writable. A time-bank commit is handed to the external counter as a one-cycle load pulse that carries all eight bytes.

Top module: `sect_reg_window`

## Requirements
- R1: After reset, rd_valid_o and time_load_o are 0, the pointer is 0x00, and every register reads as 0x00.
- R2: The address map has five sections:
  - first alarm bank at 0x00–0x07;
  - second alarm bank at 0x08–0x0F;
  - control bank at 0x10–0x13;
  - time bank at 0x30–0x37;
  - status at 0x3F.

  A read at a mapped address returns that register's committed value.
- R3: Each accepted read or write advances the pointer by one. From the last address of a section, it returns to the first address of that same section.
- R4: Status allows a single access per transfer. A second access ends the transfer: that access and every later access in it read 0x00 and are not written.
- R5: Once an address outside every section is loaded, that transfer reads 0x00 and drops all writes.
- R6: Written bytes are staged. Reads issued before the stop return the old register contents.
- R7: At a stop, staged bytes for the alarm, control or time banks are committed only if status bit 1 (write enable) is 1. A staged status byte is committed regardless of that bit.
- R8: time_i is copied into a snapshot at each start. Time-bank reads return the snapshot, even if time_i changes later in the transfer.
- R9: After a transfer, the pointer holds the address after the last one accessed, wrapped within its section. A start with no address load continues from there.
- R10: A committed time-bank write raises time_load_o for exactly one cycle, the cycle after the stop edge. In time_data_o, byte k (bits 8k+7:8k) is the byte written to 0x30+k, or the snapshot byte k where none was written.
- R11: A stop with no bytes written commits nothing and gives no load pulse.
- R12: rd_valid_o and rd_data_o answer one cycle after the clock edge that samples rd_req_i.

Verification is organised as a scoreboard, and it covers the functions that can fall in the same cycle:
- Snapshot and clock update: the bench changes time_i in the very cycle that start_i is sampled, then expects the snapshot to hold the new value. It changes time_i again between reads and expects the bytes returned to stay unchanged.
- Staging and reading: a read is issued after a control-bank write has wrapped back onto its own staged address. The bench judges that the old value comes back before the stop and the staged value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start strobe |
| stop_i | input | 1 | Transfer stop strobe |
| addr_valid_i | input | 1 | Load pointer from addr_i |
| addr_i | input | 6 | Register address |
| wr_valid_i | input | 1 | Write byte strobe |
| wr_data_i | input | 8 | Write byte |
| rd_req_i | input | 1 | Read byte request |
| time_i | input | 64 | Running time bytes, byte k at bits 8k+7:8k |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read byte |
| time_load_o | output | 1 | One-cycle load to the time counter |
| time_data_o | output | 64 | Bytes to load into the time counter |

## Verification
Two functions can meet in one cycle: the time snapshot and a clock update. The bench changes time_i in the very cycle that start_i is sampled and expects the snapshot to hold the new value. It then changes time_i again between reads and expects the returned bytes to stay unchanged. Staging and reading can also overlap in one transfer. A control-bank write is wrapped back onto its own staged address and then read: the old value must come back before the stop, and the staged value after it.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NB = 8;
  localparam int OW = $clog2(NB);
  localparam int CTL_N = 4;
  localparam int RWE_BIT = 1;
  localparam logic [AW-1:0] STA_ADDR = 6'h3F;
  localparam int STA_OFF = int'(STA_ADDR[OW-1:0]);

  typedef enum logic [2:0] {
    SEC_AL0, SEC_AL1, SEC_CTL, SEC_TIM, SEC_STA, SEC_NONE
  } sec_e;

  function automatic sec_e sec_of(logic [AW-1:0] a);
    if (a <= 6'h07) return SEC_AL0;
    if (a <= 6'h0F) return SEC_AL1;
    if (a <= 6'h13) return SEC_CTL;
    if (a >= 6'h30 && a <= 6'h37) return SEC_TIM;
    if (a == STA_ADDR) return SEC_STA;
    return SEC_NONE;
  endfunction

  function automatic logic [AW-1:0] base_of(sec_e s);
    case (s)
      SEC_AL1: return 6'h08;
      SEC_CTL: return 6'h10;
      SEC_TIM: return 6'h30;
      SEC_STA: return STA_ADDR;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [AW-1:0] last_of(sec_e s);
    case (s)
      SEC_AL0: return 6'h07;
      SEC_AL1: return 6'h0F;
      SEC_CTL: return 6'h13;
      SEC_TIM: return 6'h37;
      SEC_STA: return STA_ADDR;
      default: return 6'h00;
    endcase
  endfunction
endpackage

// File: rtl/swin_ptr.sv
module swin_ptr
  import swin_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          addr_valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          acc_i,
  output logic [AW-1:0] ptr_o,
  output sec_e          sec_o,
  output logic          ok_o
);
  logic [AW-1:0] ptr_q;
  logic          dead_q, touched_q;

  assign ptr_o = ptr_q;
  assign sec_o = sec_of(ptr_q);
  assign ok_o  = acc_i && !start_i && !addr_valid_i && !dead_q &&
                 (sec_o != SEC_NONE) && !(sec_o == SEC_STA && touched_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      dead_q    <= 1'b0;
      touched_q <= 1'b0;
    end else if (addr_valid_i) begin
      ptr_q     <= addr_i;
      dead_q    <= (sec_of(addr_i) == SEC_NONE);
      touched_q <= 1'b0;
    end else if (start_i) begin
      dead_q    <= (sec_o == SEC_NONE);
      touched_q <= 1'b0;
    end else if (ok_o) begin
      ptr_q <= (ptr_q == last_of(sec_o)) ? base_of(sec_o) : ptr_q + 1'b1;
      if (sec_o == SEC_STA) touched_q <= 1'b1;
    end else if (acc_i) begin
      dead_q <= 1'b1;
    end
  end

  // R3
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o && (ptr_q == last_of(sec_o)) |=> ptr_q == $past(base_of(sec_o)));

  // R3
  ptr_in_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |=> sec_of(ptr_q) == $past(sec_o));

  // R4
  sta_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !start_i && !addr_valid_i && sec_o == SEC_STA && touched_q |=> !ok_o);
endmodule

// File: rtl/swin_stage.sv
module swin_stage
  import swin_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [OW-1:0]          off_i,
  input  logic [DW-1:0]          data_i,
  output logic [NB-1:0][DW-1:0]  buf_o,
  output logic [NB-1:0]          mask_o,
  output logic                   any_o
);
  logic [NB-1:0][DW-1:0] buf_q;
  logic [NB-1:0]         mask_q;

  assign buf_o  = buf_q;
  assign mask_o = mask_q;
  assign any_o  = |mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      buf_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      buf_q[off_i]  <= data_i;
      mask_q[off_i] <= 1'b1;
    end
  end

  // R6
  stage_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($past(mask_q) & ~mask_q) == '0);

  // R11
  stage_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !any_o);
endmodule

// File: rtl/swin_regs.sv
module swin_regs
  import swin_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   snap_i,
  input  logic [NB*DW-1:0]       time_i,
  input  logic                   rd_req_i,
  input  logic                   rd_ok_i,
  input  logic [OW-1:0]          off_i,
  input  sec_e                   sec_i,
  input  logic                   commit_i,
  input  logic [NB-1:0][DW-1:0]  buf_i,
  input  logic [NB-1:0]          mask_i,
  output logic                   rd_valid_o,
  output logic [DW-1:0]          rd_data_o,
  output logic                   time_load_o,
  output logic [NB*DW-1:0]       time_data_o
);
  localparam int CW = $clog2(CTL_N);

  logic [NB-1:0][DW-1:0]    al0_q, al1_q, snap_q, merged;
  logic [CTL_N-1:0][DW-1:0] ctl_q;
  logic [DW-1:0]            sta_q, rd_byte;
  logic                     rwe;

  assign rwe = sta_q[RWE_BIT];

  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign merged[g] = mask_i[g] ? buf_i[g] : snap_q[g];
  end

  always_comb begin
    case (sec_i)
      SEC_AL0: rd_byte = al0_q[off_i];
      SEC_AL1: rd_byte = al1_q[off_i];
      SEC_CTL: rd_byte = ctl_q[off_i[CW-1:0]];
      SEC_TIM: rd_byte = snap_q[off_i];
      SEC_STA: rd_byte = sta_q;
      default: rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      rd_data_o  <= (rd_req_i && rd_ok_i) ? rd_byte : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (snap_i) snap_q <= time_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al0_q <= '0;
      al1_q <= '0;
      ctl_q <= '0;
      sta_q <= '0;
    end else if (commit_i) begin
      if (sec_i == SEC_STA && mask_i[STA_OFF]) sta_q <= buf_i[STA_OFF];
      if (rwe) begin
        for (int k = 0; k < NB; k++) begin
          if (mask_i[k] && sec_i == SEC_AL0) al0_q[k] <= buf_i[k];
          if (mask_i[k] && sec_i == SEC_AL1) al1_q[k] <= buf_i[k];
        end
        for (int k = 0; k < CTL_N; k++) begin
          if (mask_i[k] && sec_i == SEC_CTL) ctl_q[k] <= buf_i[k];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_load_o <= 1'b0;
      time_data_o <= '0;
    end else begin
      time_load_o <= commit_i && rwe && (sec_i == SEC_TIM);
      if (commit_i && rwe && (sec_i == SEC_TIM)) time_data_o <= merged;
    end
  end

  // R7
  rwe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !rwe |=> $stable(al0_q) && $stable(al1_q) && $stable(ctl_q) && !time_load_o);

  // R10
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |=> !time_load_o);

  // R10
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |-> $past(commit_i));

  // R8
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));

  // R12
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));
endmodule

// File: rtl/sect_reg_window.sv
module sect_reg_window
  import swin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_valid_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_req_i,
  input  logic [NB*DW-1:0] time_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             time_load_o,
  output logic [NB*DW-1:0] time_data_o
);
  logic [AW-1:0]         ptr;
  sec_e                  sec;
  logic                  ok, any;
  logic [NB-1:0][DW-1:0] stage_buf;
  logic [NB-1:0]         stage_mask;

  swin_ptr u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .acc_i        (rd_req_i | wr_valid_i),
    .ptr_o        (ptr),
    .sec_o        (sec),
    .ok_o         (ok)
  );

  swin_stage u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i | addr_valid_i | stop_i),
    .wr_i   (ok & wr_valid_i),
    .off_i  (ptr[OW-1:0]),
    .data_i (wr_data_i),
    .buf_o  (stage_buf),
    .mask_o (stage_mask),
    .any_o  (any)
  );

  swin_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snap_i      (start_i),
    .time_i      (time_i),
    .rd_req_i    (rd_req_i),
    .rd_ok_i     (ok),
    .off_i       (ptr[OW-1:0]),
    .sec_i       (sec),
    .commit_i    (stop_i & any),
    .buf_i       (stage_buf),
    .mask_i      (stage_mask),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .time_load_o (time_load_o),
    .time_data_o (time_data_o)
  );

  // R11
  no_empty_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !any |=> !time_load_o);
endmodule

// File: tb/sect_reg_window_bench.sv
module sect_reg_window_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, addr_valid_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_valid_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [63:0] time_i = '0;
  logic        rd_valid_o, time_load_o;
  logic [7:0]  rd_data_o;
  logic [63:0] time_data_o;

  int n_cmp = 0, n_bad = 0, load_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sect_reg_window u_sect_reg_window (.*);

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected read bytes
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R12", 64'(rd_data_o), 64'hx);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data_o == e, t, 64'(rd_data_o), 64'(e));
      end
    end
    if (rst_ni && time_load_o) load_cnt++;
  end

  task automatic do_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask
  task automatic do_stop();
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i) stop_i = 1'b0;
  endtask
  task automatic do_addr(logic [5:0] a);
    @(negedge clk_i) begin addr_valid_i = 1'b1; addr_i = a; end
    @(negedge clk_i) addr_valid_i = 1'b0;
  endtask
  task automatic do_wr(logic [7:0] d);
    @(negedge clk_i) begin wr_valid_i = 1'b1; wr_data_i = d; end
    @(negedge clk_i) wr_valid_i = 1'b0;
  endtask
  task automatic do_rd(logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i) rd_req_i = 1'b1;
    @(negedge clk_i) rd_req_i = 1'b0;
    check(rd_valid_o == 1'b1, "R12", 64'(rd_valid_o), 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rd_valid_o == 1'b0, "R1", 64'(rd_valid_o), 0);
    check(time_load_o == 1'b0, "R1", 64'(time_load_o), 0);
    do_start(); do_rd(8'h00, "R1"); do_stop();

    // write enable clear: alarm write dropped
    do_start(); do_addr(6'h05); do_wr(8'hAA); do_stop();
    do_start(); do_addr(6'h05); do_rd(8'h00, "R7"); do_stop();

    // status needs no enable; single access
    do_start(); do_addr(6'h3F); do_wr(8'h02); do_stop();
    do_start(); do_addr(6'h3F); do_rd(8'h02, "R7"); do_rd(8'h00, "R4"); do_wr(8'hFF); do_stop();
    do_start(); do_addr(6'h3F); do_rd(8'h02, "R4"); do_stop();

    // control bank: staged, wraps onto itself
    do_start(); do_addr(6'h12);
    do_wr(8'h44); do_wr(8'h55); do_wr(8'h66); do_wr(8'h77);
    do_rd(8'h00, "R6"); do_stop();
    do_start(); do_addr(6'h10);
    do_rd(8'h66, "R2"); do_rd(8'h77, "R2"); do_rd(8'h44, "R6"); do_rd(8'h55, "R2");
    do_rd(8'h66, "R3"); do_stop();
    do_start(); do_rd(8'h77, "R9"); do_stop();

    // second alarm bank wrap on write
    do_start(); do_addr(6'h0F); do_wr(8'h11); do_wr(8'h22); do_stop();
    do_start(); do_addr(6'h08); do_rd(8'h22, "R3"); do_stop();
    do_start(); do_addr(6'h0F); do_rd(8'h11, "R2"); do_rd(8'h22, "R3"); do_stop();

    // unmapped hole
    do_start(); do_addr(6'h20); do_wr(8'h99); do_rd(8'h00, "R5"); do_stop();
    do_start(); do_addr(6'h20); do_rd(8'h00, "R5"); do_stop();

    // snapshot: time changes in the start cycle and during reads
    @(negedge clk_i) begin time_i = 64'h3736_3534_3332_3130; start_i = 1'b1; end
    @(negedge clk_i) begin start_i = 1'b0; time_i = 64'hFFFF_FFFF_FFFF_FFFF; end
    do_addr(6'h30); do_rd(8'h30, "R8");
    time_i = 64'hEEEE_EEEE_EEEE_EEEE;
    do_rd(8'h31, "R8"); do_stop();

    // time bank commit
    @(negedge clk_i) time_i = 64'h4746_4544_4342_4140;
    do_start(); do_addr(6'h36); do_wr(8'hA6); do_wr(8'hA7); do_wr(8'hA0);
    do_stop();
    check(time_load_o == 1'b1, "R10", 64'(time_load_o), 1);
    check(time_data_o == 64'hA7A6_4544_4342_41A0, "R10", time_data_o, 64'hA7A6_4544_4342_41A0);
    @(negedge clk_i);
    check(time_load_o == 1'b0, "R10", 64'(time_load_o), 0);

    // empty stop
    do_start(); do_addr(6'h31); do_stop();
    check(time_load_o == 1'b0, "R11", 64'(time_load_o), 0);

    // enable cleared: time write gives no load
    do_start(); do_addr(6'h3F); do_wr(8'h00); do_stop();
    do_start(); do_addr(6'h30); do_wr(8'h55); do_stop();
    check(time_load_o == 1'b0, "R7", 64'(time_load_o), 0);

    repeat (3) @(negedge clk_i);
    check(load_cnt == 1, "R11", 64'(load_cnt), 1);
    check(exp_q.size() == 0, "R12", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule